// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the register front end of a multi-channel event timer. It owns the free-running 64-bit main counter, a read-only capability word, the general configuration word (global enable and legacy-route mode) and the interrupt-status word. It decodes the per-channel register windows for a set of comparator channels that live outside it. A simple 32-bit bus carries one read and/or one write per cycle with a byte address. 64-bit quantities appear as a low half at offset +0 and a high half at offset +4.

The counter is controlled by a two-state machine. In `CTR_HALTED` the counter holds its value and software may load either half. In `CTR_RUNNING` the counter advances by one every clock and load writes are dropped. The transition `START` (a configuration write with bit 0 set while halted) moves to `CTR_RUNNING` and re-arms every channel whose comparator is not all ones. The transition `STOP` (a configuration write with bit 0 clear while running) moves to `CTR_HALTED` and disarms every channel. A configuration write that leaves bit 0 unchanged keeps the state and produces no pulse.

Channel accesses in the window 0x100 to 0x3FF are forwarded as one-hot strobes, together with the offset inside the 0x20-byte channel slot. Channel read data comes back on a shared input. Pending-interrupt bits are set by the channel logic and cleared by software with write-one-to-clear.

Top module: `etr_regfile`

## Requirements
- R1: While the global enable is set, the main counter increases by exactly one every clock cycle and wraps from all ones to zero.
- R2: While the global enable is clear, the counter holds its value. Reads of 0x0F0 (bits 31:0) and 0x0F4 (bits 63:32) return the held value. Writes to those offsets load the matching half only in this state; such writes are ignored while the enable is set.
- R3: The configuration word at 0x010 has bit 0 as the global enable and bit 1 as the legacy-route mode. Both are writable, read back in place and drive `global_en` and `legacy_route` from the cycle after the write. Bits 31:2 of 0x010 and all of 0x014 read zero.
- R4: A configuration write that takes the enable from 0 to 1 raises `arm[i]` for one cycle on every channel i whose `cmp_ones[i]` is 0. A write that takes it from 1 to 0 raises `disarm` on all channels for one cycle. Any other configuration write pulses neither output.
- R5: The status word at 0x020 holds one pending bit per channel at bit i. `irq_set[i]` sets bit i. Writing 1 to bit i clears it, and bits written 0 keep their value. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: The capability low word at 0x000 reads bits 7:0 = 0x01, bits 12:8 = channel count minus one, bit 13 = 1, bit 14 = 0, bit 15 = 1 and bits 31:16 = 0. The high word at 0x004 reads the tick period in femtoseconds (`TICK_FS`).
- R7: The number of channels is `NUM_CH` raised to at least 3 and limited to at most 24. All per-channel ports have this width.
- R8: An access to an aligned address A with 0x100 <= A <= 0x3FF targets channel (A - 0x100) / 0x20. If that channel exists, `chan_wr` or `chan_rd` is one-hot on it in the same cycle, and `chan_off` carries A[4:0]. A read returns `chan_rdata`. Accesses to a channel that does not exist give no strobe and read zero.
- R9: Writes to any other offset, and all accesses whose two low address bits are not zero, change nothing and give no strobe; reads of them return zero.
- R10: `rdata` takes the read value on the clock edge that samples `rd_en` and holds it until the next read.
- R11: After reset, the counter, configuration, status, `rdata`, `arm` and `disarm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 10 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| chan_rdata | input | 32 | Read data returned by the addressed channel |
| cmp_ones | input | CH | Channel i comparator is all ones |
| irq_set | input | CH | Channel i raises its pending bit |
| count | output | 64 | Main counter value |
| global_en | output | 1 | Global enable (counter running) |
| legacy_route | output | 1 | Legacy-route mode bit |
| chan_wr | output | CH | One-hot channel write strobe |
| chan_rd | output | CH | One-hot channel read strobe |
| chan_off | output | 5 | Offset within the channel slot |
| arm | output | CH | One-cycle re-arm pulse per channel |
| disarm | output | CH | One-cycle disarm pulse per channel |
| irq_pend | output | CH | Pending interrupt bits |

## Verification
The bench builds the block with `NUM_CH = 2` and `TICK_FS = 10000000`. The count is therefore raised to three channels, which puts a real but absent channel slot at 0x160 and makes the count field read 2. Loading the counter to a value just below all ones while halted and then starting it brings the 64-bit wrap within a few dozen cycles. Directed start and stop writes, together with a pseudo-random stream over every defined and several undefined offsets, exercise both state transitions, the redundant configuration writes, and same-cycle set-and-clear on the status word.

// File: rtl/etr_pkg.sv
package etr_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int OFF_W  = 5;
    localparam int MIN_CH = 3;
    localparam int MAX_CH = 24;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_ISR    = 10'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
    localparam logic [ADDR_W-1:0] CHAN_BASE  = 10'h100;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP_LO,
        SEL_CAP_HI,
        SEL_CFG,
        SEL_ISR,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_CHAN
    } reg_sel_e;

    typedef enum logic {
        CTR_HALTED,
        CTR_RUNNING
    } ctr_state_e;

    function automatic int ch_clamp(input int n);
        if (n < MIN_CH) return MIN_CH;
        if (n > MAX_CH) return MAX_CH;
        return n;
    endfunction

endpackage

// File: rtl/etr_decode.sv
module etr_decode
    import etr_pkg::*;
#(
    parameter int CH = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [OFF_W-1:0]  ch_idx
);

    // channel slot index: slots start at 0x100, 0x20 bytes each
    assign ch_idx = addr[ADDR_W-1:5] - 5'd8;

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] != 2'b00) begin
            sel = SEL_NONE;
        end else if (addr >= CHAN_BASE) begin
            if (int'(ch_idx) < CH) sel = SEL_CHAN;
        end else begin
            unique case (addr)
                OFS_CAP_LO: sel = SEL_CAP_LO;
                OFS_CAP_HI: sel = SEL_CAP_HI;
                OFS_CFG:    sel = SEL_CFG;
                OFS_ISR:    sel = SEL_ISR;
                OFS_CNT_LO: sel = SEL_CNT_LO;
                OFS_CNT_HI: sel = SEL_CNT_HI;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/etr_counter.sv
module etr_counter
    import etr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              en_bit,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              running,
    output logic              start,
    output logic              stop
);

    ctr_state_e state_q, state_d;
    logic       inc;
    logic       load_lo_ok;
    logic       load_hi_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTR_HALTED:  if (cfg_wr && en_bit)  state_d = CTR_RUNNING;
            CTR_RUNNING: if (cfg_wr && !en_bit) state_d = CTR_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTR_HALTED;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        start      = 1'b0;
        stop       = 1'b0;
        inc        = 1'b0;
        load_lo_ok = 1'b0;
        load_hi_ok = 1'b0;
        unique case (state_q)
            CTR_HALTED: begin
                start      = cfg_wr && en_bit;
                load_lo_ok = ld_lo;
                load_hi_ok = ld_hi;
            end
            CTR_RUNNING: begin
                stop = cfg_wr && !en_bit;
                inc  = 1'b1;
            end
        endcase
    end

    assign running = (state_q == CTR_RUNNING);

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (inc)        cnt_q <= cnt_q + 64'd1;
        else if (load_lo_ok) cnt_q[31:0]  <= wdata;
        else if (load_hi_ok) cnt_q[63:32] <= wdata;
    end

    assert_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTR_RUNNING) |=> (cnt_q == $past(cnt_q) + 64'd1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTR_HALTED && !ld_lo && !ld_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/etr_status.sv
module etr_status #(
    parameter int CH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] set,
    input  logic [CH-1:0] clr,
    output logic [CH-1:0] pend
);

    // a new event in the same cycle as a clear is kept
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | set;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0));

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((pend & $past(set)) == $past(set)));

endmodule

// File: rtl/etr_regfile.sv
module etr_regfile
    import etr_pkg::*;
#(
    parameter  int NUM_CH  = 3,
    parameter  int TICK_FS = 10000000,
    localparam int CH      = etr_pkg::ch_clamp(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] chan_rdata,
    input  logic [CH-1:0]     cmp_ones,
    input  logic [CH-1:0]     irq_set,
    output logic [CNT_W-1:0]  count,
    output logic              global_en,
    output logic              legacy_route,
    output logic [CH-1:0]     chan_wr,
    output logic [CH-1:0]     chan_rd,
    output logic [OFF_W-1:0]  chan_off,
    output logic [CH-1:0]     arm,
    output logic [CH-1:0]     disarm,
    output logic [CH-1:0]     irq_pend
);

    localparam logic [DATA_W-1:0] CAP_LO =
        {16'h0000, 1'b1, 1'b0, 1'b1, 5'(CH - 1), 8'h01};
    localparam logic [DATA_W-1:0] CAP_HI = DATA_W'(TICK_FS);

    reg_sel_e         sel;
    logic [OFF_W-1:0] ch_idx;
    logic             cfg_wr;
    logic             start;
    logic             stop;
    logic [CH-1:0]    isr_clr;
    logic [DATA_W-1:0] rd_mux;

    etr_decode #(.CH(CH)) u_decode (
        .addr   (addr),
        .sel    (sel),
        .ch_idx (ch_idx)
    );

    assign cfg_wr = wr_en && (sel == SEL_CFG);

    etr_counter u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .en_bit  (wdata[0]),
        .ld_lo   (wr_en && (sel == SEL_CNT_LO)),
        .ld_hi   (wr_en && (sel == SEL_CNT_HI)),
        .wdata   (wdata),
        .cnt_q   (count),
        .running (global_en),
        .start   (start),
        .stop    (stop)
    );

    assign isr_clr = (wr_en && (sel == SEL_ISR)) ? wdata[CH-1:0] : '0;

    etr_status #(.CH(CH)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (isr_clr),
        .pend  (irq_pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_route <= 1'b0;
            arm          <= '0;
            disarm       <= '0;
        end else begin
            if (cfg_wr) legacy_route <= wdata[1];
            arm    <= start ? ~cmp_ones : '0;
            disarm <= stop ? '1 : '0;
        end
    end

    // per-channel select strobes
    assign chan_off = addr[OFF_W-1:0];
    for (genvar i = 0; i < CH; i++) begin : g_chan
        assign chan_wr[i] = wr_en && (sel == SEL_CHAN) && (int'(ch_idx) == i);
        assign chan_rd[i] = rd_en && (sel == SEL_CHAN) && (int'(ch_idx) == i);
    end

    always_comb begin
        unique case (sel)
            SEL_CAP_LO: rd_mux = CAP_LO;
            SEL_CAP_HI: rd_mux = CAP_HI;
            SEL_CFG:    rd_mux = {30'd0, legacy_route, global_en};
            SEL_ISR:    rd_mux = DATA_W'(irq_pend);
            SEL_CNT_LO: rd_mux = count[31:0];
            SEL_CNT_HI: rd_mux = count[63:32];
            SEL_CHAN:   rd_mux = chan_rdata;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|arm) |-> (global_en && !$past(global_en)));

    assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|disarm) |-> (!global_en && $past(global_en)));

    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_wr) && $onehot0(chan_rd));

    assert_nostrobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> (chan_wr == '0 && chan_rd == '0));

endmodule

// File: tb/tb_etr_regfile.sv
module tb_etr_regfile;

    localparam int CH   = 3;
    localparam int TICK = 10000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] chan_rdata;
    logic [CH-1:0] cmp_ones = '0;
    logic [CH-1:0] irq_set = '0;
    logic [63:0] count;
    logic        global_en;
    logic        legacy_route;
    logic [CH-1:0] chan_wr;
    logic [CH-1:0] chan_rd;
    logic [4:0]  chan_off;
    logic [CH-1:0] arm;
    logic [CH-1:0] disarm;
    logic [CH-1:0] irq_pend;

    int    vec = 0;
    int    mis = 0;
    string cur_tag = "R11";

    always #5 clk = ~clk;

    etr_regfile #(.NUM_CH(2), .TICK_FS(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .chan_rdata(chan_rdata),
        .cmp_ones(cmp_ones), .irq_set(irq_set), .count(count),
        .global_en(global_en), .legacy_route(legacy_route),
        .chan_wr(chan_wr), .chan_rd(chan_rd), .chan_off(chan_off),
        .arm(arm), .disarm(disarm), .irq_pend(irq_pend)
    );

    // channel side returns a recognisable word when strobed
    assign chan_rdata = (|chan_rd) ? (32'hA500_0000 | {27'd0, chan_off}) : 32'd0;

    // ---------------- reference model ----------------
    logic [63:0]   m_cnt = '0;
    logic          m_en = 1'b0;
    logic          m_leg = 1'b0;
    logic [CH-1:0] m_isr = '0;
    logic [31:0]   m_rd = '0;
    logic [CH-1:0] m_arm = '0;
    logic [CH-1:0] m_dis = '0;

    function automatic bit chan_ok(input logic [9:0] a);
        return (a >= 10'h100) && (a[1:0] == 2'b00) && (((int'(a) - 256) / 32) < CH);
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        if (chan_ok(a)) return 32'hA500_0000 | {27'd0, a[4:0]};
        case (a)
            10'h000: return 32'h0000_A001 | ((CH - 1) << 8);
            10'h004: return TICK;
            10'h010: return {30'd0, m_leg, m_en};
            10'h020: return {{(32-CH){1'b0}}, m_isr};
            10'h0F0: return m_cnt[31:0];
            10'h0F4: return m_cnt[63:32];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [63:0]   n_cnt;
        logic          n_en;
        logic          n_leg;
        logic [CH-1:0] n_isr;
        logic [31:0]   n_rd;
        logic [CH-1:0] n_arm;
        logic [CH-1:0] n_dis;
        if (!rst_n) begin
            m_cnt = '0; m_en = 0; m_leg = 0; m_isr = '0;
            m_rd = '0; m_arm = '0; m_dis = '0;
        end else begin
            n_rd  = rd_en ? exp_read(addr) : m_rd;
            n_cnt = m_en ? m_cnt + 64'd1 : m_cnt;
            n_en  = m_en; n_leg = m_leg;
            n_arm = '0; n_dis = '0;
            if (wr_en && addr == 10'h010) begin
                if (!m_en && wdata[0]) n_arm = ~cmp_ones;
                if (m_en && !wdata[0]) n_dis = '1;
                n_en  = wdata[0];
                n_leg = wdata[1];
            end
            if (wr_en && !m_en && addr == 10'h0F0) n_cnt[31:0]  = wdata;
            if (wr_en && !m_en && addr == 10'h0F4) n_cnt[63:32] = wdata;
            n_isr = m_isr;
            if (wr_en && addr == 10'h020) n_isr = m_isr & ~wdata[CH-1:0];
            n_isr = n_isr | irq_set;
            m_cnt = n_cnt; m_en = n_en; m_leg = n_leg; m_isr = n_isr;
            m_rd = n_rd; m_arm = n_arm; m_dis = n_dis;
        end
    end

    task automatic cmp(input logic [63:0] act, input logic [63:0] exp,
                       input string what, input string tag);
        vec++;
        if (act !== exp) begin
            mis++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [CH-1:0] e_wr;
            logic [CH-1:0] e_rd;
            e_wr = '0; e_rd = '0;
            if (chan_ok(addr)) begin
                e_wr[(int'(addr) - 256) / 32] = wr_en;
                e_rd[(int'(addr) - 256) / 32] = rd_en;
            end
            cmp(rdata, m_rd, "rdata", {"R10 ", cur_tag});
            cmp(count, m_cnt, "count", "R1 R2");
            cmp(global_en, m_en, "global_en", "R3");
            cmp(legacy_route, m_leg, "legacy_route", "R3");
            cmp(arm, m_arm, "arm", "R4");
            cmp(disarm, m_dis, "disarm", "R4");
            cmp(irq_pend, m_isr, "irq_pend", "R5");
            cmp(chan_wr, e_wr, "chan_wr", "R8");
            cmp(chan_rd, e_rd, "chan_rd", "R8");
            if (chan_wr != '0 || chan_rd != '0)
                cmp(chan_off, addr[4:0], "chan_off", "R8");
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(input logic w, input logic r, input logic [9:0] a,
                       input logic [31:0] d, input string t);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; cur_tag = t;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [9:0] pool [17] = '{10'h000, 10'h004, 10'h010, 10'h014, 10'h020,
                              10'h0F0, 10'h0F4, 10'h100, 10'h104, 10'h13C,
                              10'h140, 10'h15C, 10'h160, 10'h200, 10'h3FC,
                              10'h008, 10'h012};

    initial begin
        repeat (100000) @(posedge clk);
        mis++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R11 reset state
        cmp(count, 64'd0, "count", "R11");
        cmp(rdata, 64'd0, "rdata", "R11");
        cmp({global_en, legacy_route}, 64'd0, "cfg", "R11");
        cmp({arm, disarm, irq_pend}, 64'd0, "pulses", "R11");

        acc(0, 1, 10'h000, 0, "R6 R7 cap lo");
        cmp(rdata, 64'h0000_A201, "cap_lo", "R6 R7");
        acc(0, 1, 10'h004, 0, "R6 cap hi");
        cmp(rdata, 64'(TICK), "cap_hi", "R6");
        acc(0, 1, 10'h0F0, 0, "R2 held read");

        // R2 loads while halted, then R1 wrap
        acc(1, 0, 10'h0F0, 32'hFFFF_FFF0, "R2");
        acc(1, 0, 10'h0F4, 32'hFFFF_FFFF, "R2");
        acc(0, 1, 10'h0F4, 0, "R2 read hi");
        cmp(rdata, 64'hFFFF_FFFF, "cnt_hi", "R2");
        cmp(count, 64'hFFFF_FFFF_FFFF_FFF0, "count", "R2");
        cmp_ones = 3'b010;
        acc(1, 0, 10'h010, 32'h3, "R3 R4 start");
        cmp(arm, 64'(3'b101), "arm", "R4");
        idle(30);
        acc(0, 1, 10'h0F0, 0, "R1 wrap");
        acc(1, 0, 10'h0F0, 32'h1234, "R2 ignored while running");
        acc(1, 0, 10'h010, 32'hFFFF_FFFF, "R4 redundant start");
        acc(0, 1, 10'h010, 0, "R3 cfg read");
        cmp(rdata, 64'h3, "cfg", "R3");
        acc(1, 0, 10'h014, 32'hFFFF_FFFF, "R3 cfg hi write");
        acc(0, 1, 10'h014, 0, "R3 cfg hi read");
        cmp(rdata, 64'h0, "cfg_hi", "R3");
        acc(1, 0, 10'h010, 32'h0, "R4 stop");
        cmp(disarm, 64'(3'b111), "disarm", "R4");
        idle(5);
        acc(1, 0, 10'h010, 32'h0, "R4 redundant stop");
        acc(0, 1, 10'h0F0, 0, "R2 frozen read");

        // R5 status
        @(negedge clk); irq_set = 3'b111;
        @(negedge clk); irq_set = 3'b000;
        acc(1, 0, 10'h020, 32'h5, "R5 w1c");
        acc(0, 1, 10'h020, 0, "R5 read");
        cmp(rdata, 64'h2, "isr", "R5");
        @(negedge clk);
        irq_set = 3'b001; wr_en = 1; addr = 10'h020; wdata = 32'h1; cur_tag = "R5 set wins";
        @(negedge clk); irq_set = '0; wr_en = 0;
        cmp(irq_pend, 64'h3, "isr", "R5");

        // R8 / R7 / R9 channel window and undefined offsets
        acc(1, 0, 10'h100, 32'hAA, "R8 ch0 wr");
        acc(1, 0, 10'h124, 32'hBB, "R8 ch1 wr");
        acc(1, 0, 10'h148, 32'hCC, "R8 ch2 wr");
        acc(1, 0, 10'h160, 32'hDD, "R7 absent ch3 wr");
        acc(0, 1, 10'h13C, 0, "R8 ch1 rd");
        cmp(rdata, 64'hA500_001C, "chan_rd", "R8");
        acc(0, 1, 10'h160, 0, "R7 absent ch3 rd");
        cmp(rdata, 64'h0, "absent", "R7");
        acc(1, 0, 10'h0F8, 32'hFFFF_FFFF, "R9 undefined wr");
        acc(0, 1, 10'h008, 0, "R9 undefined rd");
        acc(0, 1, 10'h012, 0, "R9 misaligned rd");
        cmp(rdata, 64'h0, "misaligned", "R9");

        // pseudo-random stream
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            addr     = pool[$urandom_range(0, 16)];
            wr_en    = ($urandom_range(0, 3) == 0);
            rd_en    = ($urandom_range(0, 1) == 0);
            wdata    = $urandom;
            irq_set  = ($urandom_range(0, 3) == 0) ? CH'($urandom) : '0;
            cmp_ones = CH'($urandom);
            cur_tag  = "R3 R5 R6 R8 R9 random";
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; irq_set = '0;
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

endmodule